// File: doc/BRIEF.md
# Output-Voltage Power-Good Window Monitor

This block decides whether a regulator output is healthy. A converter front end delivers a digitized output-voltage sample and the digitized target it should match. The monitor compares the two as ratios and drives a power-good flag and an undervoltage flag. Two different windows give the flag hysteresis. It asserts only inside a narrow window around the target, and it is withdrawn only when the sample leaves a wider one. In the band between the two windows the flag keeps its last value.

The monitor stays idle until soft start reports that it is done. When a fault appears, a selectable blanking delay holds the flag high before it is pulled low. This lets a deliberate change of the target settle without a false alarm. If the fault goes away before the delay runs out, the fault is forgotten. All ratio tests use integer cross-multiplication, so no divider is needed. The blanking delays are given in time and converted to clock cycles from a clock-frequency parameter.

Top module: `pwrgood_mon`

## Requirements
- R1: After reset, `pgood` and `uv_flag` are both 0.
- R2: While `ss_done` is 0, `pgood` and `uv_flag` stay 0 whatever the sample is.
- R3: A sample/target pair is taken on a clock edge where `smp_vld` is 1. Consider a pair with 85% ≤ sample/target ≤ 110% (both bounds inclusive), taken while `ss_done` is 1 and `pgood` is 0. For such a pair, `pgood` rises on the second clock edge after the capture edge.
- R4: While `pgood` is 0, a sample outside the assert window leaves `pgood` at 0. This includes the bands from 80% to just under 85% and from just over 110% to 115%.
- R5: While `pgood` is 1, a sample in the range 80% to 115% (both inclusive) leaves `pgood` at 1.
- R6: A fault is sample/target < 80% or > 115%. A fault pulls `pgood` low N clock edges later than it would with no blanking. "No blanking" means the second edge after the capture edge. N depends on the `blank_sel` code: 00 gives 0, 01 gives 6.6 µs, 10 gives 13.2 µs and 11 gives 26.4 µs, each in clock cycles. With the default 10 MHz clock, N is 0, 66, 132 or 264.
- R7: If a fault clears before its blanking delay expires, `pgood` stays 1. A later fault then waits the full delay again.
- R8: `uv_flag` is 1 exactly when `ss_done` is 1 and sample/target < 60% (strictly). It updates on the same edge as `pgood` would.
- R9: Changing `blank_sel` while the sample is steady changes neither `pgood` nor `uv_flag`.
- R10: Changes on `smp_code`/`tgt_code` with `smp_vld` at 0 have no effect on the outputs.
- R11: When `ss_done` falls, `pgood` and `uv_flag` go to 0 on the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_vld | input | 1 | Strobe: capture sample and target this edge |
| smp_code | input | DATA_W | Digitized output-voltage sample |
| tgt_code | input | DATA_W | Digitized target voltage |
| ss_done | input | 1 | Soft start finished; monitor active |
| blank_sel | input | 2 | Blanking-delay select |
| pgood | output | 1 | Power-good flag |
| uv_flag | output | 1 | Undervoltage flag |

## Verification
The sample is swept across every region of the ratio with one fixed target. The sweep hits the exact 80%, 85%, 110% and 115% boundaries, which shows which comparisons are inclusive and which are strict. It also hits both hysteresis bands from each flag state, which separates holding from asserting. Fault timing is measured one cycle either side of the expected drop for every blanking code. A fault that clears partway through its delay, followed by a new fault, shows whether the counter restarts. Further stimulus is applied with soft start low, with an unstrobed input change and with a blanking-code change. These show that each of these leaves the flags untouched.

// File: rtl/pwrgood_pkg.sv
package pwrgood_pkg;

  // Comparator verdict for one captured sample/target pair.
  typedef struct packed {
    logic ok;   // inside the assert window
    logic flt;  // outside the deassert window
    logic uv;   // below the undervoltage ratio
  } win_t;

  // Blanking delay in clock cycles for a 2-bit select code.
  // Steps are 6.6 us multiples: cycles = kHz * 66 * mult / 10000.
  function automatic int blank_cycles(input int clk_khz, input logic [1:0] code);
    int mult;
    case (code)
      2'd0:    mult = 0;
      2'd1:    mult = 1;
      2'd2:    mult = 2;
      default: mult = 4;
    endcase
    return (clk_khz * 66 * mult) / 10000;
  endfunction

endpackage

// File: rtl/pg_sample_reg.sv
module pg_sample_reg #(
  parameter int DATA_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] smp_in,
  input  logic [DATA_W-1:0] tgt_in,
  output logic [DATA_W-1:0] smp_q,
  output logic [DATA_W-1:0] tgt_q
);

  logic [DATA_W-1:0] smp_d, tgt_d;

  always_comb begin
    smp_d = smp_q;
    tgt_d = tgt_q;
    if (load) begin
      smp_d = smp_in;
      tgt_d = tgt_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      smp_q <= '0;
      tgt_q <= '0;
    end else begin
      smp_q <= smp_d;
      tgt_q <= tgt_d;
    end
  end

endmodule

// File: rtl/pg_window_cmp.sv
module pg_window_cmp
  import pwrgood_pkg::*;
#(
  parameter int DATA_W  = 10,
  parameter int ON_LO   = 85,
  parameter int ON_HI   = 110,
  parameter int OFF_LO  = 80,
  parameter int OFF_HI  = 115,
  parameter int UV_PCT  = 60
) (
  input  logic [DATA_W-1:0] smp,
  input  logic [DATA_W-1:0] tgt,
  output win_t              verdict
);

  localparam int PW = DATA_W + 8;

  logic [PW-1:0] smp_x;
  logic [PW-1:0] on_lo_x, on_hi_x, off_lo_x, off_hi_x, uv_x;

  // Ratio tests by cross-multiplication: smp*100 against tgt*pct.
  always_comb begin
    smp_x    = PW'(smp) * PW'(100);
    on_lo_x  = PW'(tgt) * PW'(ON_LO);
    on_hi_x  = PW'(tgt) * PW'(ON_HI);
    off_lo_x = PW'(tgt) * PW'(OFF_LO);
    off_hi_x = PW'(tgt) * PW'(OFF_HI);
    uv_x     = PW'(tgt) * PW'(UV_PCT);
    verdict.ok  = (smp_x >= on_lo_x) && (smp_x <= on_hi_x);
    verdict.flt = (smp_x < off_lo_x) || (smp_x > off_hi_x);
    verdict.uv  = (smp_x < uv_x);
  end

endmodule

// File: rtl/pg_blank_timer.sv
module pg_blank_timer #(
  parameter int CNT_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [CNT_W-1:0] limit,
  output logic             expired
);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (!run)
      cnt_d = '0;
    else if (cnt_q < limit)
      cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // ">=" so that a limit lowered mid-count still ends the wait.
  assign expired = run && (cnt_q >= limit);

endmodule

// File: rtl/pwrgood_mon.sv
module pwrgood_mon
  import pwrgood_pkg::*;
#(
  parameter int DATA_W  = 10,
  parameter int CLK_KHZ = 10000,
  parameter int ON_LO   = 85,
  parameter int ON_HI   = 110,
  parameter int OFF_LO  = 80,
  parameter int OFF_HI  = 115,
  parameter int UV_PCT  = 60
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              smp_vld,
  input  logic [DATA_W-1:0] smp_code,
  input  logic [DATA_W-1:0] tgt_code,
  input  logic              ss_done,
  input  logic [1:0]        blank_sel,
  output logic              pgood,
  output logic              uv_flag
);

  localparam int LIM_MAX = blank_cycles(CLK_KHZ, 2'd3);
  localparam int CNT_W   = (LIM_MAX < 1) ? 1 : $clog2(LIM_MAX + 1);

  logic [DATA_W-1:0] smp_q, tgt_q;
  win_t              verdict;
  logic              win_ok, win_flt;
  logic [CNT_W-1:0]  lim_tab [4];
  logic [CNT_W-1:0]  limit;
  logic              blank_run, blank_done;
  logic              pg_q, pg_d, uv_q, uv_d;

  pg_sample_reg #(.DATA_W(DATA_W)) u_cap (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (smp_vld),
    .smp_in (smp_code),
    .tgt_in (tgt_code),
    .smp_q  (smp_q),
    .tgt_q  (tgt_q)
  );

  pg_window_cmp #(
    .DATA_W (DATA_W), .ON_LO(ON_LO), .ON_HI(ON_HI),
    .OFF_LO (OFF_LO), .OFF_HI(OFF_HI), .UV_PCT(UV_PCT)
  ) u_cmp (
    .smp     (smp_q),
    .tgt     (tgt_q),
    .verdict (verdict)
  );

  assign win_ok  = verdict.ok;
  assign win_flt = verdict.flt;

  for (genvar g = 0; g < 4; g++) begin : g_lim
    assign lim_tab[g] = CNT_W'(blank_cycles(CLK_KHZ, 2'(g)));
  end

  assign limit     = lim_tab[blank_sel];
  assign blank_run = ss_done && pg_q && win_flt;

  pg_blank_timer #(.CNT_W(CNT_W)) u_blank (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (blank_run),
    .limit   (limit),
    .expired (blank_done)
  );

  always_comb begin
    pg_d = pg_q;
    if (!ss_done)
      pg_d = 1'b0;
    else if (!pg_q)
      pg_d = win_ok;
    else if (blank_done)
      pg_d = 1'b0;
    uv_d = ss_done && verdict.uv;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pg_q <= 1'b0;
      uv_q <= 1'b0;
    end else begin
      pg_q <= pg_d;
      uv_q <= uv_d;
    end
  end

  assign pgood   = pg_q;
  assign uv_flag = uv_q;

endmodule

// File: rtl/pwrgood_mon_chk.sv
module pwrgood_mon_chk (
  input logic clk,
  input logic rst_n,
  input logic ss_done,
  input logic pgood,
  input logic uv_flag,
  input logic win_ok,
  input logic win_flt
);

  // R2
  pg_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ss_done |=> !pgood);

  // R3
  pg_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pgood) |-> ($past(win_ok) && $past(ss_done)));

  // R4
  pg_low_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!pgood && !win_ok) |=> !pgood);

  // R5
  pg_high_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pgood && ss_done && !win_flt) |=> pgood);

  // R6
  pg_fall_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pgood) |-> ($past(win_flt) || !$past(ss_done)));

  // R8
  uv_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(uv_flag) |-> $past(ss_done));

endmodule

bind pwrgood_mon pwrgood_mon_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .ss_done (ss_done),
  .pgood   (pgood),
  .uv_flag (uv_flag),
  .win_ok  (win_ok),
  .win_flt (win_flt)
);

// File: tb/pwrgood_mon_tb.sv
module pwrgood_mon_tb;

  localparam int CLK_PERIOD = 10;
  localparam int DATA_W     = 10;
  localparam int N1 = 66, N2 = 132, N3 = 264;

  typedef struct {
    int    cyc;
    bit    pg;
    bit    uv;
    bit    chk_uv;
    string tag;
  } exp_t;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              smp_vld = 1'b0;
  logic [DATA_W-1:0] smp_code = '0;
  logic [DATA_W-1:0] tgt_code = '0;
  logic              ss_done = 1'b0;
  logic [1:0]        blank_sel = 2'd3;
  logic              pgood, uv_flag;

  int cyc = 0;
  int n_chk = 0;
  int n_fail = 0;
  int cur_s = 0, cur_t = 0;
  bit cur_ss = 1'b0;
  bit done = 1'b0;
  exp_t q[$];

  pwrgood_mon u_dut (
    .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .smp_code(smp_code),
    .tgt_code(tgt_code), .ss_done(ss_done), .blank_sel(blank_sel),
    .pgood(pgood), .uv_flag(uv_flag)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic bit model_uv();
    return cur_ss && (cur_s * 100 < cur_t * 60);
  endfunction

  // Driver side: push expected output values for a future cycle.
  task automatic expect_at(input int c, input bit pg, input bit chk_uv, input string tag);
    exp_t e;
    e.cyc = c; e.pg = pg; e.uv = model_uv(); e.chk_uv = chk_uv; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic strobe(input int s, input int t, output int e1);
    @(negedge clk);
    smp_code = DATA_W'(s); tgt_code = DATA_W'(t); smp_vld = 1'b1;
    cur_s = s; cur_t = t;
    e1 = cyc + 2;
    @(negedge clk);
    smp_vld = 1'b0;
  endtask

  task automatic set_ss(input bit v, output int e1);
    @(negedge clk);
    ss_done = v; cur_ss = v;
    e1 = cyc + 1;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Monitor side: pop and compare at falling edges.
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].cyc <= cyc) begin
      exp_t e;
      e = q.pop_front();
      n_chk++;
      if (pgood !== e.pg || (e.chk_uv && uv_flag !== e.uv)) begin
        n_fail++;
        $display("FAIL %s @cyc %0d: pgood=%0b uv=%0b expected pgood=%0b uv=%0b",
                 e.tag, cyc, pgood, uv_flag, e.pg, e.uv);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run hung, actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int e, ef, ec;
    idle(3);
    @(negedge clk); rst_n = 1'b1;
    expect_at(cyc + 2, 0, 1, "R1 reset state");
    idle(4);

    // Soft start not done: in-window and undervoltage samples ignored
    strobe(400, 400, e); expect_at(e, 0, 1, "R2 in window without soft start");
    strobe(200, 400, e); expect_at(e, 0, 1, "R2 R8 uv gated by soft start");
    strobe(330, 400, e); idle(2);
    set_ss(1, e); expect_at(e + 2, 0, 1, "R4 82.5pct band from low");
    idle(4);
    strobe(340, 400, e); expect_at(e, 1, 1, "R3 exactly 85pct asserts");
    idle(2);
    strobe(325, 400, e); expect_at(e + 3, 1, 1, "R5 low band holds high");
    idle(4);
    strobe(455, 400, e); expect_at(e + 3, 1, 1, "R5 high band holds high");
    idle(4);
    @(negedge clk); blank_sel = 2'd0;
    expect_at(cyc + 3, 1, 1, "R9 select change keeps pgood");
    idle(4);
    strobe(319, 400, e); expect_at(e, 0, 1, "R6 code00 immediate drop");
    idle(2);
    strobe(445, 400, e); expect_at(e + 2, 0, 1, "R4 111pct band stays low");
    idle(4);
    strobe(440, 400, e); expect_at(e, 1, 1, "R3 exactly 110pct asserts");
    idle(2);

    @(negedge clk); blank_sel = 2'd1;
    strobe(461, 400, e);
    expect_at(e + N1 - 1, 1, 1, "R6 code01 still high");
    expect_at(e + N1, 0, 1, "R6 code01 drop");
    idle(N1 + 4);
    strobe(400, 400, e); expect_at(e, 1, 1, "R3 reassert");
    idle(2);

    // Fault that clears during blanking
    strobe(500, 400, ef); expect_at(ef + 10, 1, 1, "R7 blanking in progress");
    idle(28);
    strobe(400, 400, ec); expect_at(ec, 1, 1, "R7 fault cleared");
    expect_at(ef + N1 + 5, 1, 1, "R7 fault forgotten");
    idle(N1 + 10);
    strobe(100, 400, e);
    expect_at(e, 1, 1, "R8 uv at 25pct");
    expect_at(e + N1 - 1, 1, 1, "R7 full delay again");
    expect_at(e + N1, 0, 1, "R7 drop after full delay");
    idle(N1 + 4);

    strobe(240, 400, e); expect_at(e, 0, 1, "R8 exactly 60pct no uv");
    idle(2);
    strobe(239, 400, e); expect_at(e, 0, 1, "R8 below 60pct uv");
    idle(2);
    @(negedge clk); smp_code = DATA_W'(400);
    expect_at(cyc + 4, 0, 1, "R10 unstrobed change ignored");
    idle(6);
    strobe(400, 400, e); expect_at(e, 1, 1, "R3 in window");
    idle(2);

    @(negedge clk); blank_sel = 2'd2;
    expect_at(cyc + 3, 1, 1, "R9 select change keeps pgood");
    idle(4);
    strobe(320, 400, e); expect_at(e + 3, 1, 1, "R5 exactly 80pct holds");
    idle(5);
    strobe(319, 400, e);
    expect_at(e + N2 - 1, 1, 1, "R6 code10 still high");
    expect_at(e + N2, 0, 1, "R6 code10 drop");
    idle(N2 + 4);
    strobe(400, 400, e); expect_at(e, 1, 1, "R3 in window");
    idle(2);
    @(negedge clk); blank_sel = 2'd3;
    strobe(460, 400, e); expect_at(e + 3, 1, 1, "R5 exactly 115pct holds");
    idle(5);
    strobe(461, 400, e);
    expect_at(e + N3 - 1, 1, 1, "R6 code11 still high");
    expect_at(e + N3, 0, 1, "R6 code11 drop");
    idle(N3 + 4);
    strobe(400, 400, e); expect_at(e, 1, 1, "R3 in window");
    idle(3);
    strobe(200, 400, e); expect_at(e, 1, 1, "R8 uv with soft start");
    idle(3);
    set_ss(0, e); expect_at(e, 0, 1, "R11 soft start drop clears flags");
    idle(5);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule